// File: doc/BRIEF.md
# Floating-Point Status Condition and Exception Accumulator

This block keeps the 32-bit status register of a floating-point unit. Each time the datapath reports a finished result, it rewrites the four condition flags from the result's sign and class. For general arithmetic operations it also replaces the per-operation exception byte, merges that byte into the sticky accrued-exception field, and compares the exception byte with the control-register enable mask. When an enabled exception is present, it raises a one-cycle trap request.

The datapath drives `res_vld` for one cycle with the result's sign, a class code, and the exception bits that the operation raised. It also drives two qualifiers. `res_arith` marks a general arithmetic operation. `res_cmp` marks a compare, whose infinite difference must never show up as infinity in the flags. Software can overwrite the whole register through a synchronous write port, and that write wins over any result update in the same cycle.

Top module: `fp_status_accum`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `status` is 0 and `trap_req` is 0.
- R2: On a result update, all four condition flags are cleared and then rewritten from the class code. The flags are: negative at bit 27, zero at bit 26, infinity at bit 25 and NaN at bit 24. The class codes are 0 finite, 1 zero, 2 infinity, 3 quiet NaN and 4 signalling NaN; codes 5 to 7 count as finite. Zero sets only the zero flag, infinity sets only the infinity flag, either NaN sets only the NaN flag, and a finite number sets no class flag.
- R3: Bit 27 (negative) equals `res_sign` for every class, including zero, infinity and both NaNs.
- R4: A signalling-NaN result sets bit 14 (signalling-NaN exception) in addition to the NaN flag. A quiet NaN leaves bit 14 as the rest of the update makes it.
- R5: When `res_cmp` is high and the class is infinity, the flags are those of a finite number: bit 25 stays 0 and bit 27 still follows the sign.
- R6: With `res_arith` high, the exception byte `status[15:8]` is cleared and loaded with `res_exc`. With `res_arith` low, the exception byte and the accrued field keep their values, except for the bit 14 rule in R4.
- R7: The exception byte bits are: bit 15 unordered-branch, 14 signalling NaN, 13 operand error, 12 overflow, 11 underflow, 10 divide-by-zero, 9 inexact result and 8 inexact decimal input. An arithmetic update ORs bits into the accrued field as follows:
  - bit 7 (invalid) if any of bits 15, 14 or 13 is set;
  - bit 6 (overflow) if bit 12 is set;
  - bit 5 (underflow) only if bits 11 and 9 are both set;
  - bit 4 (divide-by-zero) if bit 10 is set;
  - bit 3 (inexact) if any of bits 12, 9 or 8 is set.
- R8: Accrued bits `status[7:3]` never go from 1 to 0 except through the write port.
- R9: After an arithmetic update, `trap_req` is 1 for the next cycle if the new exception byte ANDed with `ctl_en[7:0]` is nonzero. Enable bit i matches status bit 8+i. In every other cycle `trap_req` is 0.
- R10: When `wr_en` is high, `status` takes `wr_data` at the next edge, whatever the other inputs are, and `trap_req` is 0 in the following cycle.
- R11: With neither `wr_en` nor `res_vld` high, `status` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load the whole status register |
| wr_data | input | 32 | Value loaded by `wr_en` |
| res_vld | input | 1 | A result is reported this cycle |
| res_arith | input | 1 | The result comes from a general arithmetic operation |
| res_cmp | input | 1 | The result comes from a compare |
| res_sign | input | 1 | Sign of the result |
| res_class | input | 3 | Class code of the result |
| res_exc | input | 8 | Exception bits raised by the operation |
| ctl_en | input | 8 | Exception enable mask from the control register |
| status | output | 32 | Status register |
| trap_req | output | 1 | Enabled exception present |

## Verification
Every class code is driven with both signs. This separates the sign path from the class decode, and it separates a quiet NaN from a signalling NaN through bit 14.

An infinite result is sent both with and without the compare qualifier, so that the compare rule is told apart from plain class decoding. Exception bytes are sent one bit at a time, then with underflow alone and underflow plus inexact, so that each accrual rule is exercised on its own.

Non-arithmetic results that follow set accrued bits show whether the exception byte and the sticky field are preserved. A write that collides with a result shows which of the two wins. Long random runs with sparse writes compare every cycle against a behavioural model.

// File: rtl/fp_status_accum.sv
module fp_status_accum (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        res_vld,
  input  logic        res_arith,
  input  logic        res_cmp,
  input  logic        res_sign,
  input  logic [2:0]  res_class,
  input  logic [7:0]  res_exc,
  input  logic [7:0]  ctl_en,
  output logic [31:0] status,
  output logic        trap_req
);

  localparam logic [2:0] CLS_ZERO = 3'd1;
  localparam logic [2:0] CLS_INF  = 3'd2;
  localparam logic [2:0] CLS_QNAN = 3'd3;
  localparam logic [2:0] CLS_SNAN = 3'd4;

  logic [31:0] stat_q;
  logic        trap_q;

  wire is_zero = res_class == CLS_ZERO;
  wire is_inf  = res_class == CLS_INF;
  wire is_snan = res_class == CLS_SNAN;
  wire is_nan  = is_snan | (res_class == CLS_QNAN);

  // condition flags: negative, zero, infinity, NaN
  wire [3:0] cc_new = {res_sign, is_zero, is_inf & ~res_cmp, is_nan};

  wire [7:0] exc_base = res_arith ? res_exc : stat_q[15:8];
  wire [7:0] exc_new  = exc_base | {1'b0, is_snan, 6'b0};

  wire [4:0] acc_set = {
    |exc_new[7:5],
    exc_new[4],
    exc_new[3] & exc_new[1],
    exc_new[2],
    exc_new[4] | exc_new[1] | exc_new[0]
  };
  wire [4:0] acc_new = stat_q[7:3] | (res_arith ? acc_set : 5'b0);

  wire trap_hit = res_arith & |(exc_new & ctl_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      trap_q <= 1'b0;
    end else if (wr_en) begin
      stat_q <= wr_data;
      trap_q <= 1'b0;
    end else if (res_vld) begin
      stat_q <= {stat_q[31:28], cc_new, stat_q[23:16], exc_new, acc_new, stat_q[2:0]};
      trap_q <= trap_hit;
    end else begin
      trap_q <= 1'b0;
    end
  end

  assign status   = stat_q;
  assign trap_req = trap_q;

endmodule

module fp_status_accum_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        res_vld,
  input logic        res_arith,
  input logic        res_cmp,
  input logic [2:0]  res_class,
  input logic [31:0] status,
  input logic        trap_req
);

  p_write_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (status == $past(wr_data)) && !trap_req);

  p_class_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !wr_en) |=> $onehot0(status[26:24]));

  p_snan_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !wr_en && res_class == 3'd4) |=> (status[24] && status[14]));

  p_cmp_no_inf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !wr_en && res_cmp) |=> !status[25]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status[7:3] & $past(status[7:3])) == $past(status[7:3])));

  p_trap_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(res_vld && res_arith && !wr_en));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !res_vld) |=> ($stable(status) && !trap_req));

endmodule

bind fp_status_accum fp_status_accum_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .res_vld(res_vld), .res_arith(res_arith), .res_cmp(res_cmp),
  .res_class(res_class), .status(status), .trap_req(trap_req)
);

// File: tb/tb_fp_status_accum.sv
`timescale 1ns/1ps
module tb_fp_status_accum;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        res_vld = 1'b0;
  logic        res_arith = 1'b0;
  logic        res_cmp = 1'b0;
  logic        res_sign = 1'b0;
  logic [2:0]  res_class = '0;
  logic [7:0]  res_exc = '0;
  logic [7:0]  ctl_en = '0;
  logic [31:0] status;
  logic        trap_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] m_stat = '0;
  logic        m_trap = 1'b0;

  always #2.5 clk = ~clk;

  fp_status_accum dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .res_vld(res_vld), .res_arith(res_arith), .res_cmp(res_cmp),
    .res_sign(res_sign), .res_class(res_class), .res_exc(res_exc),
    .ctl_en(ctl_en), .status(status), .trap_req(trap_req)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      summary();
      $finish;
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (status !== m_stat || trap_req !== m_trap) begin
      errors++;
      $display("FAIL %s: status=%08h trap=%0b expected status=%08h trap=%0b",
               tag, status, trap_req, m_stat, m_trap);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // behavioural next-state of the reference model
  task automatic model_step();
    logic [7:0] eb;
    logic [3:0] fl;
    if (wr_en) begin
      m_stat = wr_data;
      m_trap = 1'b0;
    end else if (res_vld) begin
      fl = '0;
      fl[3] = res_sign;
      if (res_class == 3'd1) fl[2] = 1'b1;
      if (res_class == 3'd2 && !res_cmp) fl[1] = 1'b1;
      if (res_class == 3'd3 || res_class == 3'd4) fl[0] = 1'b1;
      eb = res_arith ? res_exc : m_stat[15:8];
      if (res_class == 3'd4) eb[6] = 1'b1;
      m_stat[27:24] = fl;
      m_stat[15:8] = eb;
      if (res_arith) begin
        if (eb[7] || eb[6] || eb[5]) m_stat[7] = 1'b1;
        if (eb[4]) m_stat[6] = 1'b1;
        if (eb[3] && eb[1]) m_stat[5] = 1'b1;
        if (eb[2]) m_stat[4] = 1'b1;
        if (eb[4] || eb[1] || eb[0]) m_stat[3] = 1'b1;
      end
      m_trap = res_arith && ((eb & ctl_en) != 8'h00);
    end else begin
      m_trap = 1'b0;
    end
  endtask

  task automatic apply(input bit w, input logic [31:0] wd, input bit v, input bit ar,
                       input bit cm, input bit sg, input logic [2:0] cl,
                       input logic [7:0] ex, input logic [7:0] en, input string tag);
    wr_en = w; wr_data = wd; res_vld = v; res_arith = ar; res_cmp = cm;
    res_sign = sg; res_class = cl; res_exc = ex; ctl_en = en;
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    apply(0, '0, 0, 0, 0, 0, 3'd0, 8'h00, 8'h00, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R2 R3 R4: every class with both signs, non-arithmetic
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 2; s++) begin
        apply(0, '0, 1, 0, 0, s[0], c[2:0], 8'h00, 8'h00, "R2/R3 class flags");
      end
    end
    apply(0, '0, 1, 0, 0, 1, 3'd4, 8'h00, 8'h00, "R4 signalling NaN");
    check_bit("R4 snan exception bit", status[14], 1'b1);
    check_bit("R3 negative on NaN", status[27], 1'b1);
    apply(1, 32'h0, 0, 0, 0, 0, 3'd0, 8'h00, 8'h00, "R10 clear");
    apply(0, '0, 1, 0, 0, 0, 3'd3, 8'h00, 8'h00, "R4 quiet NaN");
    check_bit("R4 quiet NaN leaves snan bit", status[14], 1'b0);

    // R5 compare with infinite difference
    apply(0, '0, 1, 0, 0, 1, 3'd2, 8'h00, 8'h00, "R5 plain infinity");
    check_bit("R5 plain inf flag", status[25], 1'b1);
    apply(0, '0, 1, 1, 1, 1, 3'd2, 8'h00, 8'h00, "R5 compare infinity");
    check_bit("R5 compare inf flag", status[25], 1'b0);
    check_bit("R5 compare sign kept", status[27], 1'b1);

    // R6 R7: single exception bits, one at a time
    for (int b = 0; b < 8; b++) begin
      apply(1, 32'h0, 0, 0, 0, 0, 3'd0, 8'h00, 8'h00, "R10 clear");
      apply(0, '0, 1, 1, 0, 0, 3'd0, 8'h01 << b, 8'h00, "R6/R7 single exception bit");
    end
    apply(1, 32'h0, 0, 0, 0, 0, 3'd0, 8'h00, 8'h00, "R10 clear");
    apply(0, '0, 1, 1, 0, 0, 3'd0, 8'h08, 8'h00, "R7 underflow alone");
    check_bit("R7 underflow without inexact", status[5], 1'b0);
    apply(0, '0, 1, 1, 0, 0, 3'd0, 8'h0A, 8'h00, "R7 underflow with inexact");
    check_bit("R7 underflow with inexact", status[5], 1'b1);

    // R8 sticky across a clean arithmetic op; R6 non-arith keeps byte
    apply(0, '0, 1, 1, 0, 0, 3'd0, 8'h10, 8'h00, "R7 overflow");
    apply(0, '0, 1, 1, 0, 0, 3'd0, 8'h00, 8'h00, "R8 sticky after clean op");
    check_bit("R8 accrued overflow held", status[6], 1'b1);
    check_bit("R6 exception byte cleared", status[12], 1'b0);
    apply(0, '0, 1, 1, 0, 0, 3'd1, 8'h24, 8'h00, "R6 load byte");
    apply(0, '0, 1, 0, 0, 0, 3'd0, 8'hFF, 8'hFF, "R6 non-arith keeps byte");
    check_bit("R9 no trap on non-arith", trap_req, 1'b0);
    idle("R11 idle hold");
    idle("R11 idle hold");

    // R9 trap enables
    apply(0, '0, 1, 1, 0, 0, 3'd0, 8'h04, 8'h04, "R9 enabled dz");
    check_bit("R9 trap on enabled", trap_req, 1'b1);
    idle("R9 trap one cycle");
    apply(0, '0, 1, 1, 0, 0, 3'd0, 8'h04, 8'hFB, "R9 disabled dz");
    check_bit("R9 no trap when masked", trap_req, 1'b0);
    apply(0, '0, 1, 1, 0, 0, 3'd4, 8'h00, 8'h40, "R9 snan class trap");

    // R10 write beats a same-cycle result
    apply(1, 32'hA5C3_1E7F, 1, 1, 0, 1, 3'd4, 8'hFF, 8'hFF, "R10 write priority");
    idle("R11 hold written value");
    apply(1, 32'h0000_0000, 0, 0, 0, 0, 3'd0, 8'h00, 8'h00, "R8 write clears accrued");

    // random run
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      apply(($urandom % 23) == 0, $urandom, r[0] | r[1], r[2], r[3], r[4],
            r[7:5], r[15:8], r[23:16], "R2/R6/R7/R9 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule